// File: doc/BRIEF.md
# Receive FIFO with Error and Overrun Control

This block holds the receive-side buffering and status of an asynchronous serial port. A bit-level receiver hands it one finished character per strobe, with a framing-error bit and a parity-error bit. The block stores these characters in a 16-deep first-in first-out buffer. Each stored entry keeps its own error bits next to the 8 data bits.

The block keeps two sticky flags. The overrun flag is set when a character arrives while the buffer is already full. The receive-error flag is set when a bad character arrives while error tolerance is off. While either flag is set, no new characters are taken in. Software clears a flag by first reading it as 1 and then writing 0 to it.

The receive-enable bit and the error-tolerance bit are supplied by the register block that surrounds this one. A low-power indication clears both flags.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: The buffer holds up to 16 entries and returns them in arrival order. `fill_o` reports the current occupancy, from 0 to 16.
- R2: An accepted arrival that meets a fill count of 16 sets `ovr_o`. The count is taken before any pop in the same cycle. The arriving character is dropped, and the stored entries stay unchanged.
- R3: While `ovr_o` is 1, arrivals are ignored and `fill_o` does not increase.
- R4: `ovr_o` resets to 0.
  - It is cleared by `standby_i`.
  - It is also cleared by a status write with `stat_wdata_ovr_i`=0, provided an earlier status read saw `ovr_o`=1 and no status write has come in between.
  - A write of 0 without such a read leaves the flag unchanged. A write of 1 has no effect.
- R5: With `rx_en_i`=0, arrivals are ignored, and neither `fill_o` nor `ovr_o` changes.
- R6: With `err_ign_i`=0, a character that has its framing or parity bit set is stored with those bits, and it sets `err_o`. Later arrivals are ignored until `err_o` is cleared.
- R7: With `err_ign_i`=1, characters with framing or parity errors are stored with their bits, `err_o` stays 0, and reception continues.
- R8: `err_o` resets to 0. It is cleared by `standby_i`, or by the same read-1-then-write-0 sequence as R4, using `stat_wdata_err_i`.
- R9: A pop on an empty buffer leaves `rd_data_o`, `rd_fer_o` and `rd_per_o` unchanged, and `fill_o` stays 0.
- R10: A pop strobe on `rd_i` presents the head entry on `rd_data_o`, `rd_fer_o` and `rd_per_o` in the next cycle. `rx_active_o` equals `rx_en_i` AND NOT `ovr_o` AND NOT `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Low-power indication; clears both flags |
| rx_en_i | input | 1 | Receive enable |
| err_ign_i | input | 1 | 1: store bad characters and keep receiving |
| char_valid_i | input | 1 | Character completed strobe |
| char_data_i | input | 8 | Received character |
| char_fer_i | input | 1 | Framing error of the character |
| char_per_i | input | 1 | Parity error of the character |
| rd_i | input | 1 | Pop strobe |
| rd_data_o | output | 8 | Last popped data |
| rd_fer_o | output | 1 | Framing error bit of the last popped entry |
| rd_per_o | output | 1 | Parity error bit of the last popped entry |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_ovr_i | input | 1 | Written value for the overrun flag |
| stat_wdata_err_i | input | 1 | Written value for the receive-error flag |
| ovr_o | output | 1 | Overrun flag |
| err_o | output | 1 | Receive-error flag |
| fill_o | output | 5 | Buffer occupancy |
| rx_active_o | output | 1 | Arrivals are currently accepted |

## Verification
A table of characters with clean, framing-only, parity-only and doubly bad error bits is pushed with tolerance on and then popped. This shows that per-entry error bits are stored exactly and that tolerance keeps reception running. A fill to 16 followed by extra arrivals separates a drop-with-overrun from an overwrite of old entries; the popped order then confirms that the 16 stored entries stayed intact. The clear sequences are tried three ways (write without a read, write of 1 after a read, and read then write 0) to tell a correct clear apart from a plain write-to-clear. A bad character with tolerance off is followed by a good one, which separates halting after the bad character from halting before it.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       fer;
    logic       per;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import uart_rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rxf_entry_t    push_entry_i,
  input  logic          pop_i,
  output rxf_entry_t    head_o,
  output logic [CW-1:0] count_o
);
  rxf_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  // callers gate on full/empty; double-guarded here
  assign do_push = push_i && (count_q != CW'(DEPTH));
  assign do_pop  = pop_i && (count_q != '0);
  assign head_o  = mem_q[rptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_entry_i;
  end
endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  logic q_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      arm_q <= 1'b0;
    end else if (clr_i) begin
      q_q   <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      // a read seeing 1 arms the clear; any write consumes the arm
      if (rd_i && q_q) arm_q <= 1'b1;
      else if (wr_i)   arm_q <= 1'b0;
      if (set_i)                          q_q <= 1'b1;
      else if (wr_i && !wdata_i && arm_q) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl
  import uart_rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic          rx_en_i,
  input  logic          err_ign_i,
  input  logic          char_valid_i,
  input  logic [7:0]    char_data_i,
  input  logic          char_fer_i,
  input  logic          char_per_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_fer_o,
  output logic          rd_per_o,
  input  logic          stat_rd_i,
  input  logic          stat_wr_i,
  input  logic          stat_wdata_ovr_i,
  input  logic          stat_wdata_err_i,
  output logic          ovr_o,
  output logic          err_o,
  output logic [CW-1:0] fill_o,
  output logic          rx_active_o
);
  rxf_entry_t    head, rd_q, in_entry;
  logic [CW-1:0] count;
  logic          accept, full, push, set_ovr, set_err, pop;

  assign full     = (count == CW'(DEPTH));
  assign accept   = char_valid_i && rx_active_o;
  assign push     = accept && !full;
  assign set_ovr  = accept && full;
  assign set_err  = push && !err_ign_i && (char_fer_i || char_per_i);
  assign pop      = rd_i && (count != '0);
  assign in_entry = '{data: char_data_i, fer: char_fer_i, per: char_per_i};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (in_entry),
    .pop_i        (pop),
    .head_o       (head),
    .count_o      (count)
  );

  rxf_sticky u_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (standby_i),
    .set_i   (set_ovr),
    .rd_i    (stat_rd_i),
    .wr_i    (stat_wr_i),
    .wdata_i (stat_wdata_ovr_i),
    .q_o     (ovr_o)
  );

  rxf_sticky u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (standby_i),
    .set_i   (set_err),
    .rd_i    (stat_rd_i),
    .wr_i    (stat_wr_i),
    .wdata_i (stat_wdata_err_i),
    .q_o     (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_q <= '0;
    else if (pop) rd_q <= head;
  end

  assign rd_data_o   = rd_q.data;
  assign rd_fer_o    = rd_q.fer;
  assign rd_per_o    = rd_q.per;
  assign fill_o      = count;
  assign rx_active_o = rx_en_i && !ovr_o && !err_o;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          standby_i,
  input logic          rx_en_i,
  input logic          char_valid_i,
  input logic          stat_wr_i,
  input logic          stat_wdata_ovr_i,
  input logic          ovr_o,
  input logic          err_o,
  input logic [CW-1:0] fill_o,
  input logic          rx_active_o
);
  assert_fill_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CW'(DEPTH));

  assert_ovr_on_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && rx_active_o && fill_o == CW'(DEPTH) && !standby_i) |=> ovr_o);

  assert_no_growth_ovr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> fill_o <= $past(fill_o));

  assert_write1_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && stat_wr_i && stat_wdata_ovr_i && !standby_i) |=> ovr_o);

  assert_disabled_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !standby_i && !stat_wr_i) |=> $stable(ovr_o));

  assert_halt_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> fill_o <= $past(fill_o));

  assert_standby_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!ovr_o && !err_o));

  assert_active_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o || err_o) |-> !rx_active_o);
endmodule

bind uart_rx_fifo_ctrl rxf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_rx_fifo_ctrl.sv
module tb_uart_rx_fifo_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       standby = 0, rx_en = 1, err_ign = 0;
  logic       cv = 0, cfer = 0, cper = 0, rd = 0;
  logic [7:0] cdata = '0;
  logic       srd = 0, swr = 0, wovr = 0, werr = 0;
  logic [7:0] rdata;
  logic       rfer, rper, ovr, err, act;
  logic [4:0] fill;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  uart_rx_fifo_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby), .rx_en_i(rx_en),
    .err_ign_i(err_ign), .char_valid_i(cv), .char_data_i(cdata),
    .char_fer_i(cfer), .char_per_i(cper), .rd_i(rd), .rd_data_o(rdata),
    .rd_fer_o(rfer), .rd_per_o(rper), .stat_rd_i(srd), .stat_wr_i(swr),
    .stat_wdata_ovr_i(wovr), .stat_wdata_err_i(werr), .ovr_o(ovr),
    .err_o(err), .fill_o(fill), .rx_active_o(act)
  );

  // {data, fer, per}
  localparam logic [9:0] VEC [8] = '{
    {8'h5A,1'b0,1'b0}, {8'hA5,1'b1,1'b0}, {8'h00,1'b0,1'b1}, {8'hFF,1'b1,1'b1},
    {8'h3C,1'b0,1'b0}, {8'hC3,1'b1,1'b0}, {8'h81,1'b0,1'b1}, {8'h7E,1'b0,1'b0}};

  task automatic check(input string req, input logic [31:0] act_v, exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, p);
    @(negedge clk); cv = 1; cdata = d; cfer = f; cper = p;
    @(negedge clk); cv = 0; cfer = 0; cper = 0;
  endtask

  task automatic pop();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic sread();
    @(negedge clk); srd = 1;
    @(negedge clk); srd = 0;
  endtask

  task automatic swrite(input logic o, e);
    @(negedge clk); swr = 1; wovr = o; werr = e;
    @(negedge clk); swr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R4 reset ovr", ovr, 0);
    check("R8 reset err", err, 0);
    check("R1 reset fill", fill, 0);
    check("R10 active after reset", act, 1);

    // R7: tolerant mode stores bad chars, keeps going
    err_ign = 1;
    for (int i = 0; i < 8; i++) push(VEC[i][9:2], VEC[i][1], VEC[i][0]);
    check("R1 fill after 8", fill, 8);
    check("R7 err stays 0", err, 0);
    check("R7 still active", act, 1);
    for (int i = 0; i < 8; i++) begin
      pop();
      check("R10 R1 popped entry", {rdata, rfer, rper}, VEC[i]);
    end
    check("R1 empty", fill, 0);

    // R9: empty pop keeps last
    pop();
    check("R9 data held", {rdata, rfer, rper}, VEC[7]);
    check("R9 fill stays 0", fill, 0);

    // R5: disabled receive
    rx_en = 0;
    push(8'h99, 0, 0);
    check("R5 fill unchanged", fill, 0);
    check("R5 ovr unchanged", ovr, 0);
    check("R10 inactive when disabled", act, 0);
    rx_en = 1;

    // R2 R3: overrun
    for (int i = 0; i < 16; i++) push(8'(i), 0, 0);
    check("R1 full", fill, 16);
    check("R2 no ovr at 16", ovr, 0);
    push(8'hAA, 0, 0);
    check("R2 ovr set", ovr, 1);
    check("R2 fill kept", fill, 16);
    pop();
    check("R3 head kept", rdata, 0);
    push(8'hBB, 0, 0);
    check("R3 ignored while ovr", fill, 15);
    rx_en = 0;
    push(8'hCC, 0, 0);
    check("R5 ovr kept with rx off", ovr, 1);
    rx_en = 1;

    // R4 clear sequence
    swrite(0, 0);
    check("R4 write0 without read", ovr, 1);
    sread();
    swrite(1, 0);
    check("R4 write1 no effect", ovr, 1);
    swrite(0, 0);
    check("R4 arm consumed by write", ovr, 1);
    sread();
    swrite(0, 0);
    check("R4 read then write0 clears", ovr, 0);
    for (int i = 1; i < 16; i++) begin
      pop();
      check("R2 old entries intact", rdata, 32'(i));
    end
    check("R1 drained", fill, 0);

    // R6 halt policy
    err_ign = 0;
    push(8'h11, 0, 0);
    push(8'h22, 1, 0);
    check("R6 err set", err, 1);
    push(8'h33, 0, 0);
    check("R6 halted fill", fill, 2);
    pop();
    check("R6 good entry", {rdata, rfer, rper}, {8'h11, 2'b00});
    pop();
    check("R6 bad entry marked", {rdata, rfer, rper}, {8'h22, 2'b10});
    swrite(0, 0);
    check("R8 write0 without read", err, 1);
    sread();
    swrite(0, 0);
    check("R8 cleared", err, 0);
    push(8'h44, 0, 1);
    check("R6 parity halts", err, 1);
    check("R6 stored", fill, 1);

    // standby clears both
    for (int i = 0; i < 20; i++) push(8'h55, 0, 0);
    @(negedge clk); standby = 1;
    @(negedge clk); standby = 0;
    check("R8 standby clears err", err, 0);
    check("R4 standby clears ovr", ovr, 0);
    check("R10 active again", act, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule